// File: doc/BRIEF.md
# Prescaled Countdown Timer with Autoreload

This block is a register-mapped down-counting timer for a processor core. Software programs a count, a reload value and a prescale divisor, then turns the timer on. While the timer runs, the count drops by one on every prescaled tick. When it reaches zero, the timer latches a sticky expiry flag and drives a level interrupt. It then either parks at zero (one-shot) or reloads the count from the period register and keeps counting (periodic).

The timer has two separate gating controls: a power bit and a run bit. Counting happens only when both are set. The bus is a single-cycle strobe interface. A write takes effect on the clock edge that samples it. Read data is combinational from the current register state. Any interrupt vectoring or handling is the job of the core.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: Registers sit at byte offsets 0x0 (control), 0x4 (period), 0x8 (scale) and 0xC (count). Any other offset reads zero. Control bits 31:4 and scale bits 31:8 read as zero.
- R3: Control bit 0 (power) and bit 1 (run) must both be set for the count to change. With either bit clear the count holds, while period and count stay writable and readable.
- R4: With scale value S, the count drops once every S+1 clocks of counting, and the first drop comes S+1 clocks after counting starts. The prescaler is cleared whenever counting is off. A write to scale restarts the prescaler from zero, and no tick occurs on that cycle.
- R5: With control bit 2 (autoreload) set, an expiry loads the count from the period register and counting continues.
- R6: With control bit 2 clear, an expiry leaves the count at 0. The count stays there while the timer keeps running.
- R7: An expiry is a tick that takes the count from 1 to 0. It sets control bit 3 (expiry flag). After a one-shot expiry the control register reads 0xB; after a periodic one it reads 0xF.
- R8: `irq` equals the expiry flag. Writing 1 to control bit 3 clears the flag. Writing 0 to it leaves the flag unchanged.
- R9: A write to the count register takes effect on that edge, even while counting, and replaces the decrement of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the timer |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| irq | output | 1 | Level interrupt, high while the expiry flag is set |

## Verification
Several properties are checked on every cycle, no matter what software writes:
- a stopped timer never changes its count,
- each tick lowers the count by exactly one,
- an expiry either parks the count at zero or loads the period,
- the expiry flag only falls through an explicit clear,
- ticks never come back to back when the scale is non-zero.

Other behaviour can only be shown by the bench's scenarios. These include the exact cycle of each decrement for a given scale, the restart of the prescaler on a scale write, the control readback values 0xB, 0xF and 0xD, the masking of unused register bits, and a count write replacing a pending decrement.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  // byte offsets of the registers
  localparam int unsigned OFF_CTRL   = 'h0;
  localparam int unsigned OFF_PERIOD = 'h4;
  localparam int unsigned OFF_SCALE  = 'h8;
  localparam int unsigned OFF_COUNT  = 'hC;

  // control bit positions
  localparam int unsigned CB_PWR  = 0;
  localparam int unsigned CB_RUN  = 1;
  localparam int unsigned CB_ARL  = 2;
  localparam int unsigned CB_FLAG = 3;
  localparam int unsigned CTRL_BITS = 4;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int unsigned SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [SCALE_W-1:0] pre_q;

  function automatic logic [SCALE_W-1:0] pre_next(input logic [SCALE_W-1:0] p,
                                                   input logic hit);
    return hit ? '0 : p + SCALE_W'(1);
  endfunction

  assign tick = run && !restart && (pre_q == scale);

  always_ff @(posedge clk) begin
    if (!rst_n)               pre_q <= '0;
    else if (!run || restart) pre_q <= '0;
    else                      pre_q <= pre_next(pre_q, tick);
  end

  // R4: with a non-zero divisor two ticks are never adjacent
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && scale != '0 && !restart) |=> !tick);
endmodule

// File: rtl/tmr_down.sv
`timescale 1ns/1ps
module tmr_down #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         autoreload,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] count_q;

  function automatic logic [W-1:0] after_tick(input logic [W-1:0] c,
                                              input logic arl,
                                              input logic [W-1:0] per);
    if (c == '0)          return '0;
    else if (c == W'(1))  return arl ? per : '0;
    else                  return c - W'(1);
  endfunction

  assign expire = tick && !load && (count_q == W'(1));
  assign count  = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    count_q <= '0;
    else if (load) count_q <= load_val;
    else if (tick) count_q <= after_tick(count_q, autoreload, period);
  end

  // R3: no tick and no write means no change
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q));
  // R4: one tick removes exactly one
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count_q > W'(1)) |=> (count_q == $past(count_q) - W'(1)));
  // R5: periodic expiry loads the period
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && autoreload) |=> (count_q == $past(period)));
  // R6: one-shot expiry parks at zero
  a_r6_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !autoreload) |=> (count_q == '0));
endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned SCALE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFF_PERIOD);
  localparam logic [ADDR_W-1:0] A_SCALE  = ADDR_W'(OFF_SCALE);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);

  logic               pwr_q, run_en_q, arl_q, flag_q;
  logic [DATA_W-1:0]  period_q;
  logic [SCALE_W-1:0] scale_q;
  logic [DATA_W-1:0]  count;
  logic               wr_ctrl, wr_period, wr_scale, wr_count;
  logic               counting, tick, expire, flag_clr;

  assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_period = bus_sel && bus_wr && (bus_addr == A_PERIOD);
  assign wr_scale  = bus_sel && bus_wr && (bus_addr == A_SCALE);
  assign wr_count  = bus_sel && bus_wr && (bus_addr == A_COUNT);
  assign counting  = pwr_q && run_en_q;
  assign flag_clr  = wr_ctrl && bus_wdata[CB_FLAG];

  tmr_prescale #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(counting), .restart(wr_scale),
    .scale(scale_q), .tick(tick)
  );

  tmr_down #(.W(DATA_W)) u_down (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_count),
    .load_val(bus_wdata), .autoreload(arl_q), .period(period_q),
    .count(count), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q    <= 1'b0;
      run_en_q <= 1'b0;
      arl_q    <= 1'b0;
      flag_q   <= 1'b0;
      period_q <= '0;
      scale_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        pwr_q    <= bus_wdata[CB_PWR];
        run_en_q <= bus_wdata[CB_RUN];
        arl_q    <= bus_wdata[CB_ARL];
      end
      if (wr_period) period_q <= bus_wdata;
      if (wr_scale)  scale_q  <= bus_wdata[SCALE_W-1:0];
      flag_q <= expire || (flag_q && !flag_clr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:   bus_rdata[CTRL_BITS-1:0] = {flag_q, arl_q, run_en_q, pwr_q};
      A_PERIOD: bus_rdata = period_q;
      A_SCALE:  bus_rdata[SCALE_W-1:0] = scale_q;
      A_COUNT:  bus_rdata = count;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag_q;

  // R3: gating stops the prescaler outright
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_q && run_en_q) |-> !tick);
  // R7: every expiry leaves the flag set
  a_r7_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (flag_q && irq));
  // R8: the flag only drops through a write of 1 to its bit
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  prescaled_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #6;
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  // monitor: compares each read against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (bus_sel && !bus_wr) begin
        if (exp_q.size() == 0) check("monitor queue underflow", 32'h1, 32'h0);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h0, 32'h0, "R1 ctrl");
    rd(5'h4, 32'h0, "R1 period");
    rd(5'h8, 32'h0, "R1 scale");
    rd(5'hC, 32'h0, "R1 count");
    chk_irq(1'b0, "R1 irq");

    // R2 map and masking
    wr(5'h4, 32'h10);
    wr(5'h8, 32'h1FF);
    wr(5'h0, 32'hFFFF_FFF1);
    rd(5'h4, 32'h10, "R2 period");
    rd(5'h8, 32'hFF, "R2 scale mask");
    rd(5'h0, 32'h1, "R2 ctrl mask");
    rd(5'h10, 32'h0, "R2 unmapped 0x10");
    rd(5'h2, 32'h0, "R2 unmapped 0x2");
    wr(5'hC, 32'hABCD);
    rd(5'hC, 32'hABCD, "R2 count readback");

    // R3 run bit without power
    wr(5'h0, 32'h2);
    wr(5'hC, 32'h3);
    rd(5'hC, 32'h3, "R3 hold a");
    rd(5'hC, 32'h3, "R3 hold b");
    rd(5'hC, 32'h3, "R3 hold c");
    rd(5'h0, 32'h2, "R3 ctrl");

    // R6 / R7 one-shot, divisor 1
    wr(5'h8, 32'h0);
    wr(5'h0, 32'h1);
    wr(5'hC, 32'h3);
    wr(5'h0, 32'h3);
    rd(5'hC, 32'h3, "R6 count 3");
    rd(5'hC, 32'h2, "R6 count 2");
    rd(5'hC, 32'h1, "R6 count 1");
    rd(5'hC, 32'h0, "R6 count 0");
    rd(5'hC, 32'h0, "R6 parked");
    rd(5'h0, 32'hB, "R7 ctrl oneshot");
    chk_irq(1'b1, "R7 irq set");

    // R8 clear semantics
    wr(5'h0, 32'h3);
    rd(5'h0, 32'hB, "R8 write0 keeps flag");
    chk_irq(1'b1, "R8 irq kept");
    wr(5'h0, 32'h9);
    rd(5'h0, 32'h1, "R8 write1 clears");
    chk_irq(1'b0, "R8 irq cleared");

    // R4 divisor 3
    wr(5'hC, 32'h5);
    wr(5'h8, 32'h2);
    wr(5'h0, 32'h3);
    rd(5'hC, 32'h5, "R4 p0");
    rd(5'hC, 32'h5, "R4 p1");
    rd(5'hC, 32'h5, "R4 p2");
    rd(5'hC, 32'h4, "R4 p3");
    rd(5'hC, 32'h4, "R4 p4");
    rd(5'hC, 32'h4, "R4 p5");
    rd(5'hC, 32'h3, "R4 p6");

    // R4 scale write restarts prescaler
    wr(5'h0, 32'h1);
    wr(5'hC, 32'h5);
    wr(5'h0, 32'h3);
    rd(5'hC, 32'h5, "R4 restart a");
    wr(5'h8, 32'h2);
    rd(5'hC, 32'h5, "R4 restart b");
    rd(5'hC, 32'h5, "R4 restart c");
    rd(5'hC, 32'h5, "R4 restart d");
    rd(5'hC, 32'h4, "R4 restart e");

    // R9 count write overrides decrement
    wr(5'h0, 32'h1);
    wr(5'h8, 32'h0);
    wr(5'hC, 32'd10);
    wr(5'h0, 32'h3);
    wr(5'hC, 32'd7);
    rd(5'hC, 32'd7, "R9 override");
    rd(5'hC, 32'd6, "R9 resumes");

    // R5 autoreload
    wr(5'h0, 32'h1);
    wr(5'h4, 32'h4);
    wr(5'hC, 32'h2);
    wr(5'h0, 32'h7);
    rd(5'hC, 32'h2, "R5 a");
    rd(5'hC, 32'h1, "R5 b");
    rd(5'hC, 32'h4, "R5 reload 1");
    rd(5'hC, 32'h3, "R5 c");
    rd(5'hC, 32'h2, "R5 d");
    rd(5'hC, 32'h1, "R5 e");
    rd(5'hC, 32'h4, "R5 reload 2");
    rd(5'h0, 32'hF, "R7 ctrl periodic");
    chk_irq(1'b1, "R5 irq");
    wr(5'h0, 32'h5);
    rd(5'h0, 32'hD, "R8 stopped flag kept");
    chk_irq(1'b1, "R8 irq kept 2");
    wr(5'h0, 32'hD);
    rd(5'h0, 32'h5, "R8 cleared 2");
    chk_irq(1'b0, "R8 irq low 2");
    rd(5'hC, 32'h1, "R3 stopped hold a");
    rd(5'hC, 32'h1, "R3 stopped hold b");

    @(negedge clk);
    bus_sel = 1'b0;
    repeat (2) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule